// File: doc/BRIEF.md
# Peripheral Register Bus Fabric

This block joins one bus master, typically a small soft processor, to a set of register-file peripherals over a 16-bit memory-mapped bus. The master presents an address and write data, together with separate read, write and address-valid strobes and a transfer-size qualifier. Each peripheral owns one 16-byte window of the address space. The window is chosen by a base value that is compared against the upper twelve address bits. The fabric turns the address into one select line per peripheral.

Each peripheral holds eight 16-bit registers and handles byte and halfword lanes itself. It drives its read output to zero whenever it is not selected for a read. Because of this, the fabric builds the returned read data by OR-ing the outputs of all peripherals, with no multiplexer. Writes commit on a clock edge. Reads are combinational and valid in the same cycle as the read strobe.

Top module: `pbus_fabric`

## Requirements
- R1: Peripheral i is selected (slave_sel[i] = 1) exactly when as_stb is 1 and addr[15:4] equals that peripheral's 12-bit base. With the default bases 0x000, 0x012 and 0xA5C, at most one select is high, and none is high for any other address.
- R2: A halfword write (size = 1, wr_stb = 1, as_stb = 1) to a selected peripheral loads wdata into register addr[3:1] at the rising clock edge. addr[0] is ignored for halfword transfers.
- R3: A byte write (size = 0) with addr[0] = 0 loads wdata[7:0] into bits [7:0] of register addr[3:1]. With addr[0] = 1 it loads wdata[7:0] into bits [15:8]. The other byte of that register keeps its value.
- R4: A halfword read (size = 1, rd_stb = 1, as_stb = 1) of a mapped address returns the full 16-bit register on rdata in the same cycle.
- R5: A byte read returns the byte chosen by addr[0] (0 = bits [7:0], 1 = bits [15:8]) on rdata[7:0], with rdata[15:8] = 0.
- R6: rdata is 0x0000 whenever rd_stb or as_stb is low.
- R7: A read of an address whose addr[15:4] matches no base returns 0x0000. A write to such an address changes no register in any peripheral.
- R8: A write needs both wr_stb and as_stb high at the clock edge. wr_stb alone or as_stb alone changes no register.
- R9: With rst_n low at a rising clock edge, every register in every peripheral becomes 0x0000.
- R10: A peripheral that is not selected for a read drives zero into the OR-combine. A read of one peripheral therefore returns only that peripheral's data, whatever the others hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Byte address: [15:4] window base, [3:1] register, [0] byte lane |
| wdata | input | 16 | Write data; byte writes use [7:0] |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| as_stb | input | 1 | Address-valid strobe qualifying every transfer |
| size | input | 1 | Transfer size: 0 = byte, 1 = halfword |
| rdata | output | 16 | OR-combined read data |
| slave_sel | output | NUM_SLAVES | Per-peripheral select lines |

## Verification
The hardest case to reach from the ports is showing that a write to an unmapped address leaves every register untouched. A single stray write cannot be seen until the affected register is read back. The stimulus therefore first fills every mapped register with a distinct known pattern. It then writes all-ones to every one of the 65,488 unmapped addresses in turn, and finally reads each mapped register back. A full read sweep over all 65,536 addresses also checks the select lines and rdata against a model of the bases at every address. This covers the boundary offsets next to each window.

// File: rtl/pbus_pkg.sv
// Package pbus_pkg
// Shared widths and request type for the peripheral register bus.
// Assumes byte addressing with halfword registers inside 16-byte windows.
package pbus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int OFS_W  = 4;
    localparam int BASE_W = ADDR_W - OFS_W;
    localparam int IDX_W  = OFS_W - 1;
    localparam int NREG   = 2 ** IDX_W;

    typedef enum logic {
        XFER_BYTE = 1'b0,
        XFER_HALF = 1'b1
    } xfer_size_e;

    // Fields a peripheral needs; its select already includes the address strobe.
    typedef struct packed {
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] wdata;
        logic              rd;
        logic              wr;
        xfer_size_e        size;
    } slave_req_t;
endpackage

// File: rtl/pbus_addr_decode.sv
// Module pbus_addr_decode
// Compares the upper address bits with each peripheral base and raises that
// peripheral's select while the address strobe is high.
// Assumes the bases are distinct; clk/rst_n serve only the assertion.
module pbus_addr_decode
    import pbus_pkg::*;
#(
    parameter int                         NUM_SLAVES = 3,
    parameter logic [NUM_SLAVES*BASE_W-1:0] BASES     = {12'hA5C, 12'h012, 12'h000}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  as_stb,
    output logic [NUM_SLAVES-1:0] sel
);
    // One comparator per peripheral window.
    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_cmp
        assign sel[i] = as_stb && (addr[ADDR_W-1:OFS_W] == BASES[i*BASE_W +: BASE_W]);
    end

    // R1: distinct windows never overlap
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/pbus_reg_slave.sv
// Module pbus_reg_slave
// Sample peripheral: NREG halfword registers with byte-lane writes and a
// read output gated to zero unless selected for a read.
// Assumes sel already contains the address-strobe qualification.
module pbus_reg_slave
    import pbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  slave_req_t        req,
    output logic [DATA_W-1:0] rd_data
);
    logic [NREG-1:0][DATA_W-1:0] regs;
    logic [IDX_W-1:0]            idx;
    logic                        lane;
    logic                        wr_en;
    logic                        rd_en;
    logic [DATA_W-1:0]           cur;

    assign idx   = req.ofs[OFS_W-1:1];
    assign lane  = req.ofs[0];
    assign wr_en = sel && req.wr;
    assign rd_en = sel && req.rd;
    assign cur   = regs[idx];

    // Register update: reset clear, then halfword or single-lane write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            if (req.size == XFER_HALF)
                regs[idx] <= req.wdata;
            else if (lane)
                regs[idx][15:8] <= req.wdata[7:0];
            else
                regs[idx][7:0] <= req.wdata[7:0];
        end
    end

    // Read path: zero when not selected for a read so the OR-combine works.
    always_comb begin
        if (!rd_en)
            rd_data = '0;
        else if (req.size == XFER_HALF)
            rd_data = cur;
        else if (lane)
            rd_data = {8'h00, cur[15:8]};
        else
            rd_data = {8'h00, cur[7:0]};
    end

    // R10: unselected peripheral contributes nothing
    a_r10_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));
    // R8: no qualified write, no register change
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
    // R2: halfword write lands whole
    a_r2_half_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req.size == XFER_HALF) |=> (regs[$past(idx)] == $past(req.wdata)));
    // R3: low-lane write keeps the upper byte
    a_r3_keep_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req.size == XFER_BYTE && !lane) |=>
        (regs[$past(idx)][15:8] == $past(cur[15:8])));
    // R3: high-lane write keeps the lower byte
    a_r3_keep_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req.size == XFER_BYTE && lane) |=>
        (regs[$past(idx)][7:0] == $past(cur[7:0])));
endmodule

// File: rtl/pbus_or_merge.sv
// Module pbus_or_merge
// Combines peripheral read outputs with a bitwise OR.
// Assumes every input not being read is driven to zero.
module pbus_or_merge
    import pbus_pkg::*;
#(
    parameter int NUM_SLAVES = 3
) (
    input  logic [NUM_SLAVES-1:0][DATA_W-1:0] din,
    output logic [DATA_W-1:0]                 dout
);
    // OR-reduce across peripherals.
    always_comb begin
        dout = '0;
        for (int i = 0; i < NUM_SLAVES; i++)
            dout = dout | din[i];
    end
endmodule

// File: rtl/pbus_fabric.sv
// Module pbus_fabric
// Top of the peripheral register bus: decodes the address into selects,
// fans the request out to NUM_SLAVES register peripherals and merges
// their read data by OR. Assumes one master and distinct bases.
module pbus_fabric
    import pbus_pkg::*;
#(
    parameter int                           NUM_SLAVES = 3,
    parameter logic [NUM_SLAVES*BASE_W-1:0] BASES      = {12'hA5C, 12'h012, 12'h000}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           addr,
    input  logic [15:0]           wdata,
    input  logic                  rd_stb,
    input  logic                  wr_stb,
    input  logic                  as_stb,
    input  logic                  size,
    output logic [15:0]           rdata,
    output logic [NUM_SLAVES-1:0] slave_sel
);
    slave_req_t                        req;
    logic [NUM_SLAVES-1:0][DATA_W-1:0] slave_rd;

    // Request bundle shared by every peripheral.
    always_comb begin
        req.ofs   = addr[OFS_W-1:0];
        req.wdata = wdata;
        req.rd    = rd_stb;
        req.wr    = wr_stb;
        req.size  = xfer_size_e'(size);
    end

    pbus_addr_decode #(.NUM_SLAVES(NUM_SLAVES), .BASES(BASES)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .as_stb (as_stb),
        .sel    (slave_sel)
    );

    for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_slv
        pbus_reg_slave u_slv (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (slave_sel[i]),
            .req     (req),
            .rd_data (slave_rd[i])
        );
    end

    pbus_or_merge #(.NUM_SLAVES(NUM_SLAVES)) u_merge (
        .din  (slave_rd),
        .dout (rdata)
    );

    // R6: no read strobe pair, no read data
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && as_stb) |-> (rdata == 16'h0000));
    // R7: unmapped address reads as zero
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_sel == '0) |-> (rdata == 16'h0000));
    // R5: byte reads clear the upper lane
    a_r5_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
        !size |-> (rdata[15:8] == 8'h00));
endmodule

// File: tb/pbus_fabric_test.sv
// Bench for pbus_fabric: full address sweeps against a bench-side model.
module pbus_fabric_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0, wdata = '0;
    logic        rd_stb = 1'b0, wr_stb = 1'b0, as_stb = 1'b0, size = 1'b0;
    logic [15:0] rdata;
    logic [2:0]  slave_sel;

    int checks = 0;
    int errors = 0;
    logic [15:0] mem [3][8];
    localparam logic [11:0] B0 = 12'h000, B1 = 12'h012, B2 = 12'hA5C;

    always #4 clk = ~clk;

    pbus_fabric uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .as_stb(as_stb), .size(size),
        .rdata(rdata), .slave_sel(slave_sel)
    );

    function automatic int slot(input logic [15:0] a);
        if (a[15:4] == B0) return 0;
        if (a[15:4] == B1) return 1;
        if (a[15:4] == B2) return 2;
        return -1;
    endfunction

    function automatic logic [15:0] base_addr(input int s);
        case (s)
            0: return {B0, 4'h0};
            1: return {B1, 4'h0};
            default: return {B2, 4'h0};
        endcase
    endfunction

    function automatic logic [15:0] exp_rd(input logic [15:0] a, input logic rd, input logic as_, input logic sz);
        int s = slot(a);
        logic [15:0] v;
        if (s < 0 || !rd || !as_) return 16'h0000;
        v = mem[s][a[3:1]];
        if (sz) return v;
        return a[0] ? {8'h00, v[15:8]} : {8'h00, v[7:0]};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, settle, leave for the rising edge.
    task automatic bus(input logic [15:0] a, input logic [15:0] d,
                       input logic rd, input logic wr, input logic as_, input logic sz);
        @(negedge clk);
        addr = a; wdata = d; rd_stb = rd; wr_stb = wr; as_stb = as_; size = sz;
        #1;
    endtask

    task automatic wr_model(input logic [15:0] a, input logic [15:0] d, input logic sz);
        int s = slot(a);
        if (s >= 0) begin
            if (sz) mem[s][a[3:1]] = d;
            else if (a[0]) mem[s][a[3:1]][15:8] = d[7:0];
            else mem[s][a[3:1]][7:0] = d[7:0];
        end
    endtask

    task automatic readback_all(input string tag);
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 8; r++) begin
                logic [15:0] a = base_addr(s) | 16'(r * 2);
                bus(a, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
                check(tag, rdata, exp_rd(a, 1'b1, 1'b1, 1'b1));
            end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 8; r++) mem[s][r] = 16'h0000;
        // Dirty writes during reset must be cleared (R9).
        rst_n = 1'b0;
        bus(16'h0002, 16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b1);
        bus(16'h0002, 16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b1);
        bus(16'h0000, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        readback_all("R9 reset clear");

        // R2: halfword writes, odd address on some to show addr[0] ignored.
        for (int s = 0; s < 3; s++)
            for (int r = 0; r < 8; r++) begin
                logic [15:0] a = base_addr(s) | 16'(r * 2 + (r % 2));
                logic [15:0] d = 16'(16'h1111 * (s + 1) ^ (r * 16'h0203) ^ 16'h8000);
                bus(a, d, 1'b0, 1'b1, 1'b1, 1'b1);
                wr_model(a, d, 1'b1);
            end
        readback_all("R2 halfword write / R4 halfword read / R10 merge");

        // R5: byte reads on both lanes of every register.
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 16; k++) begin
                logic [15:0] a = base_addr(s) | 16'(k);
                bus(a, 16'h0, 1'b1, 1'b0, 1'b1, 1'b0);
                check("R5 byte read", rdata, exp_rd(a, 1'b1, 1'b1, 1'b0));
            end

        // R3: byte writes to each lane; upper wdata byte must not matter.
        for (int s = 0; s < 3; s++)
            for (int k = 0; k < 16; k += 3) begin
                logic [15:0] a = base_addr(s) | 16'(k);
                logic [15:0] d = 16'(16'hC300 | (k * 7 + s));
                bus(a, d, 1'b0, 1'b1, 1'b1, 1'b0);
                wr_model(a, d, 1'b0);
            end
        readback_all("R3 byte write lanes");

        // R8: write strobe alone and address strobe alone.
        for (int s = 0; s < 3; s++) begin
            bus(base_addr(s) | 16'h4, 16'h5A5A, 1'b0, 1'b1, 1'b0, 1'b1);
            bus(base_addr(s) | 16'h6, 16'hA5A5, 1'b0, 1'b0, 1'b1, 1'b1);
            bus(base_addr(s) | 16'h9, 16'h00FF, 1'b1, 1'b0, 1'b1, 1'b0);
            check("R8 byte read after lone strobes", rdata, exp_rd(base_addr(s) | 16'h9, 1'b1, 1'b1, 1'b0));
        end
        readback_all("R8 lone strobes no write");

        // R6: read data zero with either read qualifier missing.
        for (int s = 0; s < 3; s++) begin
            bus(base_addr(s) | 16'h2, 16'h0, 1'b0, 1'b0, 1'b1, 1'b1);
            check("R6 as only", rdata, 16'h0000);
            bus(base_addr(s) | 16'h2, 16'h0, 1'b1, 1'b0, 1'b0, 1'b1);
            check("R6 rd only", rdata, 16'h0000);
            check("R1 no select without as_stb", {13'h0, slave_sel}, 16'h0000);
        end

        // R1/R4/R7: read every address and compare data and selects.
        for (int a = 0; a < 65536; a++) begin
            logic [15:0] ad = 16'(a);
            int s = slot(ad);
            bus(ad, 16'h0, 1'b1, 1'b0, 1'b1, 1'b1);
            check("R4/R7 sweep read", rdata, exp_rd(ad, 1'b1, 1'b1, 1'b1));
            check("R1 select decode", {13'h0, slave_sel}, (s < 0) ? 16'h0 : 16'(1 << s));
        end

        // R7: write all-ones to every unmapped address, then read back.
        for (int a = 0; a < 65536; a++) begin
            logic [15:0] ad = 16'(a);
            if (slot(ad) < 0) bus(ad, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1);
        end
        readback_all("R7 unmapped write no effect");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule